// File: doc/BRIEF.md
# Multi-Thread Register Renamer

This block renames groups of instructions issued by several hardware threads onto one shared pool of physical registers. Each thread owns a private table from logical to physical registers, so the same logical name used by two threads never refers to the same physical register. A single circular free list, shared by all threads, supplies new physical tags for destinations and takes back tags that commit logic releases.

Each cycle one thread may present a group of up to three instruction slots, each with two logical sources and one optional logical destination. When the group is accepted, the block returns for every slot the physical source tags, the new physical destination tag and the previous mapping of that destination, so that the old register can be released once the instruction retires. Dependencies between slots of the same group are resolved inside the group, before the table update takes effect. When the free list cannot cover every destination of the group, the whole group is held off.

Top module: `rename_unit`

## Requirements
- R1: After reset, logical register i of thread t maps to physical tag t*32+i, the free list holds tags 128 to 191 with 128 at its head, `inReady` is high for any group and `outValid` is low.
- R2: Destination tags are taken from the head of the free list in slot order (slot 0 first); tags released later are handed out after all tags already in the list, in first-in first-out order.
- R3: A source that no earlier valid slot of the group writes is translated through the presenting thread's table; one thread's writes never change another thread's translation.
- R4: A source equal to the logical destination of an earlier valid slot in the same group takes that slot's new physical tag; with several such slots, the latest earlier one wins.
- R5: The old mapping of a destination is the table entry of the presenting thread, or the new tag of the latest earlier slot in the group writing the same logical register.
- R6: When the free list holds fewer tags than the number of slots with both slot-valid and destination-valid set, `inReady` is low, the group is not renamed, no output is produced and neither the tables nor the free list change.
- R7: A group whose slots have no destination is accepted even when the free list is empty.
- R8: Up to three tags per cycle are released through `relVld`/`relTag`, appended to the free list in port-index order (index 0 first); a tag released in a cycle counts toward `inReady` and allocation only from the next cycle on.
- R9: A group is accepted on a rising clock edge where `inValid` and `inReady` are both high; its results appear with `outValid` high right after that edge and stay until the next acceptance.
- R10: All destination tags handed out within one group are distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | A group is presented |
| inThread | input | 2 | Thread issuing the group |
| inSlotVld | input | 3 | Per-slot valid, bit k is slot k |
| inDstVld | input | 3 | Per-slot destination present, bit k is slot k |
| inSrcA | input | 3x5 | First logical source per slot, element k is slot k |
| inSrcB | input | 3x5 | Second logical source per slot |
| inDst | input | 3x5 | Logical destination per slot |
| inReady | output | 1 | Free list can cover the presented group |
| relVld | input | 3 | Release port valid per lane |
| relTag | input | 3x8 | Physical tag released per lane |
| outValid | output | 1 | Renamed group results are valid |
| outSlotVld | output | 3 | Slot valid of the renamed group |
| outDstVld | output | 3 | Slot valid and destination present of the renamed group |
| outSrcA | output | 3x8 | Physical tag of first source per slot |
| outSrcB | output | 3x8 | Physical tag of second source per slot |
| outDst | output | 3x8 | New physical destination tag per slot |
| outOldDst | output | 3x8 | Previous mapping of the destination per slot |

## Verification
`inReady` is combinational on the presented group and the registered free count, so it is sampled a moment after the inputs change and before the accepting edge. All renamed results are registered once, so they are read at the falling edge after the accepting rising edge. A release takes effect at the edge where it is presented, which is why a release made together with a short group is checked for a still-low `inReady` in that same cycle and a high one in the following cycle.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int RN_NTHR  = 4;
  localparam int RN_NLOG  = 32;
  localparam int RN_NPHYS = 192;
  localparam int RN_GRP   = 3;
  localparam int RN_NREL  = 3;

  localparam int RN_TW  = (RN_NTHR > 1) ? $clog2(RN_NTHR) : 1;
  localparam int RN_LW  = $clog2(RN_NLOG);
  localparam int RN_PW  = $clog2(RN_NPHYS);
  localparam int RN_CW  = $clog2(((RN_GRP > RN_NREL) ? RN_GRP : RN_NREL) + 1);

  // strobes from control to datapath
  typedef struct packed {
    logic              fire;
    logic [RN_CW-1:0]  allocN;
  } rnStrobe_t;
endpackage

// File: rtl/rn_ctrl.sv
module rn_ctrl
  import rn_pkg::*;
#(
  parameter int NTHR  = RN_NTHR,
  parameter int NLOG  = RN_NLOG,
  parameter int NPHYS = RN_NPHYS,
  parameter int GRP   = RN_GRP,
  parameter int NREL  = RN_NREL
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [GRP-1:0]  inSlotVld,
  input  logic [GRP-1:0]  inDstVld,
  input  logic [NREL-1:0] relVld,
  output logic            inReady,
  output rnStrobe_t       strb
);
  localparam int FCW   = $clog2(NPHYS + 1);
  localparam int NINIT = NTHR * NLOG;

  logic [FCW-1:0]   freeCnt;
  logic [RN_CW-1:0] needed;
  logic [RN_CW-1:0] relN;

  always_comb begin
    needed  = RN_CW'($countones(inSlotVld & inDstVld));
    relN    = RN_CW'($countones(relVld));
    inReady = (freeCnt >= FCW'(needed));
    strb.fire   = inValid & inReady;
    strb.allocN = strb.fire ? needed : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeCnt <= FCW'(NPHYS - NINIT);
    end else begin
      freeCnt <= freeCnt - FCW'(strb.allocN) + FCW'(relN);
    end
  end
endmodule

// File: rtl/rn_datapath.sv
module rn_datapath
  import rn_pkg::*;
#(
  parameter int NTHR  = RN_NTHR,
  parameter int NLOG  = RN_NLOG,
  parameter int NPHYS = RN_NPHYS,
  parameter int GRP   = RN_GRP,
  parameter int NREL  = RN_NREL,
  parameter int TW    = RN_TW,
  parameter int LW    = RN_LW,
  parameter int PW    = RN_PW
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rnStrobe_t                strb,
  input  logic [TW-1:0]            inThread,
  input  logic [GRP-1:0]           inSlotVld,
  input  logic [GRP-1:0]           inDstVld,
  input  logic [GRP-1:0][LW-1:0]   inSrcA,
  input  logic [GRP-1:0][LW-1:0]   inSrcB,
  input  logic [GRP-1:0][LW-1:0]   inDst,
  input  logic [NREL-1:0]          relVld,
  input  logic [NREL-1:0][PW-1:0]  relTag,
  output logic                     outValid,
  output logic [GRP-1:0]           outSlotVld,
  output logic [GRP-1:0]           outDstVld,
  output logic [GRP-1:0][PW-1:0]   outSrcA,
  output logic [GRP-1:0][PW-1:0]   outSrcB,
  output logic [GRP-1:0][PW-1:0]   outDst,
  output logic [GRP-1:0][PW-1:0]   outOldDst
);
  localparam int FLD   = 2 ** PW;
  localparam int NINIT = NTHR * NLOG;
  localparam int NFREE = NPHYS - NINIT;

  logic [PW-1:0] mapTab [NTHR][NLOG];
  logic [PW-1:0] flMem  [FLD];
  logic [PW-1:0] head, tail;

  logic [GRP-1:0]          wrSlot;
  logic [GRP-1:0][PW-1:0]  newTag, physA, physB, oldTag;
  logic [NREL-1:0][PW-1:0] relAddr;

  assign wrSlot = inSlotVld & inDstVld;

  // tag pick from free-list head, in slot order
  always_comb begin
    int c;
    c = 0;
    for (int k = 0; k < GRP; k++) begin
      newTag[k] = flMem[head + PW'(c)];
      if (wrSlot[k]) c++;
    end
  end

  // release lanes packed at the tail in lane order
  always_comb begin
    int c;
    c = 0;
    for (int r = 0; r < NREL; r++) begin
      relAddr[r] = tail + PW'(c);
      if (relVld[r]) c++;
    end
  end

  // table lookup with in-group forwarding, latest earlier writer wins
  always_comb begin
    for (int k = 0; k < GRP; k++) begin
      physA[k]  = mapTab[inThread][inSrcA[k]];
      physB[k]  = mapTab[inThread][inSrcB[k]];
      oldTag[k] = mapTab[inThread][inDst[k]];
      for (int j = 0; j < GRP; j++) begin
        if (j < k && wrSlot[j]) begin
          if (inDst[j] == inSrcA[k]) physA[k]  = newTag[j];
          if (inDst[j] == inSrcB[k]) physB[k]  = newTag[j];
          if (inDst[j] == inDst[k])  oldTag[k] = newTag[j];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < NTHR; t++)
        for (int i = 0; i < NLOG; i++)
          mapTab[t][i] <= PW'(t * NLOG + i);
      for (int i = 0; i < FLD; i++)
        flMem[i] <= (i < NFREE) ? PW'(NINIT + i) : '0;
      head <= '0;
      tail <= PW'(NFREE);
    end else begin
      if (strb.fire) begin
        for (int k = 0; k < GRP; k++)
          if (wrSlot[k]) mapTab[inThread][inDst[k]] <= newTag[k];
      end
      for (int r = 0; r < NREL; r++)
        if (relVld[r]) flMem[relAddr[r]] <= relTag[r];
      head <= head + PW'(strb.allocN);
      tail <= tail + PW'($countones(relVld));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outSlotVld <= '0;
      outDstVld  <= '0;
      outSrcA    <= '0;
      outSrcB    <= '0;
      outDst     <= '0;
      outOldDst  <= '0;
    end else begin
      outValid <= strb.fire;
      if (strb.fire) begin
        outSlotVld <= inSlotVld;
        outDstVld  <= wrSlot;
        outSrcA    <= physA;
        outSrcB    <= physB;
        outDst     <= newTag;
        outOldDst  <= oldTag;
      end
    end
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rn_pkg::*;
#(
  parameter int NTHR  = RN_NTHR,
  parameter int NLOG  = RN_NLOG,
  parameter int NPHYS = RN_NPHYS,
  parameter int GRP   = RN_GRP,
  parameter int NREL  = RN_NREL,
  parameter int TW    = RN_TW,
  parameter int LW    = RN_LW,
  parameter int PW    = RN_PW
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [TW-1:0]            inThread,
  input  logic [GRP-1:0]           inSlotVld,
  input  logic [GRP-1:0]           inDstVld,
  input  logic [GRP-1:0][LW-1:0]   inSrcA,
  input  logic [GRP-1:0][LW-1:0]   inSrcB,
  input  logic [GRP-1:0][LW-1:0]   inDst,
  output logic                     inReady,
  input  logic [NREL-1:0]          relVld,
  input  logic [NREL-1:0][PW-1:0]  relTag,
  output logic                     outValid,
  output logic [GRP-1:0]           outSlotVld,
  output logic [GRP-1:0]           outDstVld,
  output logic [GRP-1:0][PW-1:0]   outSrcA,
  output logic [GRP-1:0][PW-1:0]   outSrcB,
  output logic [GRP-1:0][PW-1:0]   outDst,
  output logic [GRP-1:0][PW-1:0]   outOldDst
);
  rnStrobe_t strb;

  rn_ctrl #(
    .NTHR(NTHR), .NLOG(NLOG), .NPHYS(NPHYS), .GRP(GRP), .NREL(NREL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inSlotVld(inSlotVld), .inDstVld(inDstVld), .relVld(relVld),
    .inReady(inReady), .strb(strb)
  );

  rn_datapath #(
    .NTHR(NTHR), .NLOG(NLOG), .NPHYS(NPHYS), .GRP(GRP), .NREL(NREL),
    .TW(TW), .LW(LW), .PW(PW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inThread(inThread),
    .inSlotVld(inSlotVld), .inDstVld(inDstVld),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .inDst(inDst),
    .relVld(relVld), .relTag(relTag),
    .outValid(outValid), .outSlotVld(outSlotVld), .outDstVld(outDstVld),
    .outSrcA(outSrcA), .outSrcB(outSrcB), .outDst(outDst), .outOldDst(outOldDst)
  );
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk
  import rn_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       inValid,
  input logic                       inReady,
  input logic [RN_GRP-1:0]          inSlotVld,
  input logic [RN_GRP-1:0]          inDstVld,
  input logic [RN_GRP-1:0][RN_LW-1:0] inSrcA,
  input logic [RN_GRP-1:0][RN_LW-1:0] inDst,
  input logic                       outValid,
  input logic [RN_GRP-1:0]          outDstVld,
  input logic [RN_GRP-1:0][RN_PW-1:0] outSrcA,
  input logic [RN_GRP-1:0][RN_PW-1:0] outDst,
  input logic [RN_GRP-1:0][RN_PW-1:0] outOldDst
);
  AST_STALL_NO_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inReady) |=> !outValid); // R6

  AST_FIRE_GIVES_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid); // R9

  AST_NODEST_READY: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ((inSlotVld & inDstVld) == '0)) |-> inReady); // R7

  AST_DST_DISTINCT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !((outDstVld[0] && outDstVld[1] && outDst[0] == outDst[1]) ||
                   (outDstVld[0] && outDstVld[2] && outDst[0] == outDst[2]) ||
                   (outDstVld[1] && outDstVld[2] && outDst[1] == outDst[2]))); // R10

  AST_FWD_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inSlotVld[0] && inDstVld[0] && inSlotVld[1] &&
     inSrcA[1] == inDst[0]) |=> (outSrcA[1] == outDst[0])); // R4

  AST_FWD_OLD: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inSlotVld[0] && inDstVld[0] && inSlotVld[1] &&
     inDstVld[1] && !(inSlotVld[2] && inDstVld[2] && 1'b0) &&
     inDst[1] == inDst[0]) |=> (outOldDst[1] == outDst[0])); // R5
endmodule

bind rename_unit rename_unit_chk i_chk (.*);

// File: tb/test_rename_unit.sv
module test_rename_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]      thr;
    logic [2:0]      sv;
    logic [2:0]      dv;
    logic [2:0][4:0] a;
    logic [2:0][4:0] b;
    logic [2:0][4:0] d;
    logic [2:0][7:0] ea;
    logic [2:0][7:0] eb;
    logic [2:0][7:0] ed;
    logic [2:0][7:0] eo;
  } vec_t;

  // slot 2 is the leftmost element of each concatenation
  localparam vec_t VEC [5] = '{
    '{2'd0, 3'b111, 3'b111, {5'd1,5'd1,5'd2}, {5'd4,5'd5,5'd3}, {5'd1,5'd4,5'd1},
      {8'd128,8'd128,8'd2}, {8'd129,8'd5,8'd3}, {8'd130,8'd129,8'd128}, {8'd128,8'd4,8'd1}},
    '{2'd1, 3'b111, 3'b101, {5'd1,5'd1,5'd1}, {5'd0,5'd2,5'd4}, {5'd7,5'd0,5'd1},
      {8'd131,8'd131,8'd33}, {8'd32,8'd34,8'd36}, {8'd132,8'd0,8'd131}, {8'd39,8'd0,8'd33}},
    '{2'd0, 3'b101, 3'b101, {5'd2,5'd0,5'd1}, {5'd1,5'd0,5'd4}, {5'd3,5'd0,5'd2},
      {8'd133,8'd0,8'd130}, {8'd130,8'd0,8'd129}, {8'd134,8'd0,8'd133}, {8'd3,8'd0,8'd2}},
    '{2'd3, 3'b111, 3'b111, {5'd31,5'd31,5'd31}, {5'd30,5'd31,5'd0}, {5'd0,5'd31,5'd31},
      {8'd136,8'd135,8'd127}, {8'd126,8'd135,8'd96}, {8'd137,8'd136,8'd135}, {8'd96,8'd135,8'd127}},
    '{2'd2, 3'b001, 3'b000, {5'd0,5'd0,5'd1}, {5'd0,5'd0,5'd4}, {5'd0,5'd0,5'd0},
      {8'd0,8'd0,8'd65}, {8'd0,8'd0,8'd68}, {8'd0,8'd0,8'd0}, {8'd0,8'd0,8'd0}}
  };

  logic clk = 1'b0;
  logic rstN;
  logic inValid;
  logic [1:0] inThread;
  logic [2:0] inSlotVld, inDstVld;
  logic [2:0][4:0] inSrcA, inSrcB, inDst;
  logic inReady;
  logic [2:0] relVld;
  logic [2:0][7:0] relTag;
  logic outValid;
  logic [2:0] outSlotVld, outDstVld;
  logic [2:0][7:0] outSrcA, outSrcB, outDst, outOldDst;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_unit i_rename_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inThread(inThread),
    .inSlotVld(inSlotVld), .inDstVld(inDstVld),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .inDst(inDst), .inReady(inReady),
    .relVld(relVld), .relTag(relTag),
    .outValid(outValid), .outSlotVld(outSlotVld), .outDstVld(outDstVld),
    .outSrcA(outSrcA), .outSrcB(outSrcB), .outDst(outDst), .outOldDst(outOldDst)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic present(input logic [1:0] thr, input logic [2:0] sv, input logic [2:0] dv,
                         input logic [2:0][4:0] a, input logic [2:0][4:0] b,
                         input logic [2:0][4:0] d);
    inValid = 1'b1; inThread = thr; inSlotVld = sv; inDstVld = dv;
    inSrcA = a; inSrcB = b; inDst = d;
  endtask

  task automatic idle();
    inValid = 1'b0; inSlotVld = '0; inDstVld = '0;
  endtask

  initial begin
    rstN = 1'b0; relVld = '0; relTag = '0;
    inThread = '0; inSrcA = '0; inSrcB = '0; inDst = '0;
    idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, a full group is coverable, no output
    inSlotVld = 3'b111; inDstVld = 3'b111;
    #1;
    chk("R1", "inReady after reset", int'(inReady), 1);
    chk("R1", "outValid after reset", int'(outValid), 0);
    @(negedge clk);
    chk("R1", "no output while inValid low", int'(outValid), 0);

    // table walk: R1 R2 R3 R4 R5 R9 R10
    for (int v = 0; v < 5; v++) begin
      present(VEC[v].thr, VEC[v].sv, VEC[v].dv, VEC[v].a, VEC[v].b, VEC[v].d);
      @(negedge clk);
      idle();
      chk("R9", "outValid one cycle after accept", int'(outValid), 1);
      for (int k = 0; k < 3; k++) begin
        if (VEC[v].sv[k]) begin
          chk("R3/R4", $sformatf("row %0d slot %0d srcA", v, k), int'(outSrcA[k]), int'(VEC[v].ea[k]));
          chk("R3/R4", $sformatf("row %0d slot %0d srcB", v, k), int'(outSrcB[k]), int'(VEC[v].eb[k]));
        end
        if (VEC[v].sv[k] && VEC[v].dv[k]) begin
          chk("R2/R10", $sformatf("row %0d slot %0d dst", v, k), int'(outDst[k]), int'(VEC[v].ed[k]));
          chk("R5", $sformatf("row %0d slot %0d old", v, k), int'(outOldDst[k]), int'(VEC[v].eo[k]));
        end
      end
    end

    // R2: drain the remaining 54 tags in ascending order
    for (int g = 0; g < 18; g++) begin
      present(2'd2, 3'b111, 3'b111, '0, '0, {5'd12,5'd11,5'd10});
      #1;
      chk("R2", $sformatf("drain %0d ready", g), int'(inReady), 1);
      @(negedge clk);
      idle();
      chk("R2", $sformatf("drain %0d slot0 dst", g), int'(outDst[0]), 138 + 3*g);
      chk("R2", $sformatf("drain %0d slot2 dst", g), int'(outDst[2]), 140 + 3*g);
    end

    // R6: empty free list stalls a group with a destination
    present(2'd0, 3'b001, 3'b001, '0, '0, {5'd0,5'd0,5'd9});
    #1;
    chk("R6", "ready low with empty list", int'(inReady), 0);
    @(negedge clk);
    idle();
    chk("R6", "no output for stalled group", int'(outValid), 0);

    // R7: group without destinations accepted; R6: stalled write left r9 untouched
    present(2'd0, 3'b011, 3'b000, {5'd0,5'd1,5'd9}, {5'd0,5'd4,5'd9}, '0);
    #1;
    chk("R7", "ready for dest-less group", int'(inReady), 1);
    @(negedge clk);
    idle();
    chk("R7", "dest-less group output", int'(outValid), 1);
    chk("R6", "r9 mapping unchanged by stall", int'(outSrcA[0]), 9);
    chk("R3", "thread0 r1 mapping", int'(outSrcA[1]), 130);
    chk("R3", "thread0 r4 mapping", int'(outSrcB[1]), 129);

    // R8: release in the same cycle does not satisfy the group
    relVld = 3'b001; relTag[0] = 8'd5;
    present(2'd0, 3'b001, 3'b001, {5'd0,5'd0,5'd9}, {5'd0,5'd0,5'd9}, {5'd0,5'd0,5'd9});
    #1;
    chk("R8", "same-cycle release not usable", int'(inReady), 0);
    @(negedge clk);
    relVld = '0;
    chk("R8", "no output in release cycle", int'(outValid), 0);
    #1;
    chk("R8", "released tag usable next cycle", int'(inReady), 1);
    @(negedge clk);
    idle();
    chk("R8", "output after release", int'(outValid), 1);
    chk("R8", "released tag allocated", int'(outDst[0]), 5);
    chk("R5", "old mapping of r9", int'(outOldDst[0]), 9);
    chk("R3", "r9 source before update", int'(outSrcA[0]), 9);

    // R8: three lanes, appended in lane order
    relVld = 3'b111; relTag = {8'd12, 8'd11, 8'd10};
    @(negedge clk);
    relVld = '0;
    present(2'd1, 3'b111, 3'b111, {5'd2,5'd1,5'd0}, {5'd7,5'd7,5'd7}, {5'd3,5'd2,5'd1});
    #1;
    chk("R8", "ready after three-lane release", int'(inReady), 1);
    @(negedge clk);
    idle();
    chk("R8", "lane0 tag to slot0", int'(outDst[0]), 10);
    chk("R8", "lane1 tag to slot1", int'(outDst[1]), 11);
    chk("R8", "lane2 tag to slot2", int'(outDst[2]), 12);
    chk("R4", "slot1 forwarded src", int'(outSrcA[1]), 10);
    chk("R4", "slot2 forwarded src", int'(outSrcA[2]), 11);
    chk("R3", "slot0 table src", int'(outSrcA[0]), 32);
    chk("R3", "thread1 r7 mapping", int'(outSrcB[0]), 132);
    chk("R5", "slot0 old", int'(outOldDst[0]), 131);
    chk("R5", "slot2 old", int'(outOldDst[2]), 35);

    @(negedge clk);
    chk("R9", "outValid drops without accept", int'(outValid), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule